// File: doc/BRIEF.md
# Index-Register Effective Address Unit

This unit turns the addressing part of a memory-referencing instruction into an effective address. Each request carries a 2-bit mode and a 10-bit displacement. The unit combines them with a 32-bit index register that it holds itself. Two of the four modes also step that register: one adds one after the address is formed, and the other subtracts one before the address is formed.

A core presents at most one request per clock with a valid strobe. One cycle later the unit returns the full 32-bit sum, which serves instructions that use the address as an immediate value. It also returns the 10-bit memory or branch address, a write-enable flag and the index value that follows the request. The core can load the index register through a separate port when no request is active, and can read it at any time.

Top module: `idx_ea_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `xr_value` becomes 0 and `res_valid` and `res_xr_we` become 0.
- R2: Mode 0 (direct): `res_sum` equals the zero-extended displacement, `res_xr_we` is 0 and the index register does not change.
- R3: Mode 1 (indexed): `res_sum` equals the displacement plus the index register, `res_xr_we` is 0 and the index register does not change.
- R4: Mode 2 (post-increment): `res_sum` equals the displacement plus the index value before the request, `res_xr_we` is 1, and the index register becomes the old value plus one.
- R5: Mode 3 (pre-decrement): the index register becomes the old value minus one, `res_sum` equals the displacement plus that new value, and `res_xr_we` is 1.
- R6: `res_ea` is always the low 10 bits of `res_sum`, so a sum above 1023 wraps to its low 10 bits.
- R7: `res_valid` is high in the cycle after each clock edge at which `req_valid` was high, and low otherwise. The result fields belong to that request.
- R8: `res_xr_new` equals the index value after the request. `xr_value` shows it from the cycle after the request, so a back-to-back request uses the updated index.
- R9: When `xr_load_en` is high and `req_valid` is low at a clock edge, `xr_value` becomes `xr_load_val`.
- R10: When `xr_load_en` and `req_valid` are both high, the load has no effect and the request decides the index value.
- R11: Increment and decrement of the index wrap modulo 2^32: 0xFFFFFFFF plus one gives 0, and 0 minus one gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 2 | Addressing mode: 0 direct, 1 indexed, 2 post-increment, 3 pre-decrement |
| req_disp | input | 10 | Displacement field of the instruction |
| xr_load_en | input | 1 | Load the index register (only when no request) |
| xr_load_val | input | 32 | Value to load |
| xr_value | output | 32 | Current index register |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_ea | output | 10 | Truncated effective address |
| res_sum | output | 32 | Full 32-bit address sum |
| res_xr_we | output | 1 | Request changed the index register |
| res_xr_new | output | 32 | Index value after the request |

## Verification
The hardest situations to reach are the wrap points of the index register and a load that collides with a request. The port sequence cannot simply count the register up to 0xFFFFFFFF. Instead, the bench loads that value through the load port while no request is active, then issues a post-increment. It then issues a pre-decrement from 0 and checks both the wrapped index and the sum that uses it. Collisions are created by raising the load strobe in the same cycle as a request. The bench then reads the index back to confirm that the request's value was kept. Back-to-back auto-index requests check that each request uses the value left by the one before.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT  = 2'd0,
    AM_INDEXED = 2'd1,
    AM_POSTINC = 2'd2,
    AM_PREDEC  = 2'd3
  } amode_e;
endpackage

// File: rtl/idx_ea_calc.sv
// Combinational address and index-step logic for one request.
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int DISP_W = 10,
  parameter int XR_W   = 32
) (
  input  amode_e            mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [XR_W-1:0]   xr_cur,
  output logic [XR_W-1:0]   sum,
  output logic [XR_W-1:0]   xr_next,
  output logic              xr_we
);
  logic [XR_W-1:0] base;
  logic [XR_W-1:0] disp_ext;

  assign disp_ext = XR_W'(disp);

  always_comb begin
    base    = xr_cur;
    xr_next = xr_cur;
    xr_we   = 1'b0;
    unique case (mode)
      AM_DIRECT:  base = '0;
      AM_INDEXED: base = xr_cur;
      AM_POSTINC: begin
        base    = xr_cur;
        xr_next = xr_cur + XR_W'(1);
        xr_we   = 1'b1;
      end
      AM_PREDEC: begin
        xr_next = xr_cur - XR_W'(1);
        base    = xr_next;
        xr_we   = 1'b1;
      end
      default: base = '0;
    endcase
  end

  assign sum = disp_ext + base;
endmodule

// File: rtl/idx_xr_reg.sv
// Index register: request update wins over external load.
module idx_xr_reg #(
  parameter int XR_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_en,
  input  logic [XR_W-1:0] upd_val,
  input  logic            ld_en,
  input  logic [XR_W-1:0] ld_val,
  output logic [XR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (upd_en) q <= upd_val;
    else if (ld_en)  q <= ld_val;
  end
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int DISP_W = 10,
  parameter int XR_W   = 32,
  parameter int EA_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              xr_load_en,
  input  logic [XR_W-1:0]   xr_load_val,
  output logic [XR_W-1:0]   xr_value,
  output logic              res_valid,
  output logic [EA_W-1:0]   res_ea,
  output logic [XR_W-1:0]   res_sum,
  output logic              res_xr_we,
  output logic [XR_W-1:0]   res_xr_new
);
  logic [XR_W-1:0] c_sum;
  logic [XR_W-1:0] c_next;
  logic            c_we;
  logic            upd_en;
  logic            ld_en;

  idx_ea_calc #(.DISP_W(DISP_W), .XR_W(XR_W)) u_calc (
    .mode    (amode_e'(req_mode)),
    .disp    (req_disp),
    .xr_cur  (xr_value),
    .sum     (c_sum),
    .xr_next (c_next),
    .xr_we   (c_we)
  );

  assign upd_en = req_valid & c_we;
  assign ld_en  = xr_load_en & ~req_valid;

  idx_xr_reg #(.XR_W(XR_W)) u_xr (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_val (c_next),
    .ld_en   (ld_en),
    .ld_val  (xr_load_val),
    .q       (xr_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_ea     <= '0;
      res_sum    <= '0;
      res_xr_we  <= 1'b0;
      res_xr_new <= '0;
    end else begin
      res_valid <= req_valid;
      res_xr_we <= req_valid & c_we;
      if (req_valid) begin
        res_sum    <= c_sum;
        res_ea     <= c_sum[EA_W-1:0];
        res_xr_new <= c_next;
      end
    end
  end
endmodule

// File: rtl/idx_ea_unit_chk.sv
module idx_ea_unit_chk #(
  parameter int DISP_W = 10,
  parameter int XR_W   = 32,
  parameter int EA_W   = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_mode,
  input logic [DISP_W-1:0] req_disp,
  input logic              xr_load_en,
  input logic [XR_W-1:0]   xr_load_val,
  input logic [XR_W-1:0]   xr_value,
  input logic              res_valid,
  input logic [EA_W-1:0]   res_ea,
  input logic [XR_W-1:0]   res_sum,
  input logic              res_xr_we,
  input logic [XR_W-1:0]   res_xr_new
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r7_no_stray: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  a_r2_direct_sum: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd0) |=> res_sum == XR_W'($past(req_disp)));
  a_r3_index_kept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_mode[1]) |=> $stable(xr_value));
  a_r8_reg_matches: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> xr_value == res_xr_new);
  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && xr_load_en) |=> xr_value == $past(xr_load_val));
  a_r6_ea_low: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_ea == res_sum[EA_W-1:0]);
  a_r4_we_only_valid: assert property (@(posedge clk) disable iff (rst)
    res_xr_we |-> res_valid);
endmodule

bind idx_ea_unit idx_ea_unit_chk #(.DISP_W(DISP_W), .XR_W(XR_W), .EA_W(EA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
  .req_disp(req_disp), .xr_load_en(xr_load_en), .xr_load_val(xr_load_val),
  .xr_value(xr_value), .res_valid(res_valid), .res_ea(res_ea),
  .res_sum(res_sum), .res_xr_we(res_xr_we), .res_xr_new(res_xr_new)
);

// File: tb/tb_idx_ea_unit.sv
module tb_idx_ea_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [9:0]  req_disp = '0;
  logic        xr_load_en = 1'b0;
  logic [31:0] xr_load_val = '0;
  logic [31:0] xr_value;
  logic        res_valid;
  logic [9:0]  res_ea;
  logic [31:0] res_sum;
  logic        res_xr_we;
  logic [31:0] res_xr_new;

  typedef struct {
    logic [31:0] sum;
    logic        we;
    logic [31:0] xnew;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  logic [31:0] mxr = '0;
  bit          done = 0;

  idx_ea_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_disp(req_disp), .xr_load_en(xr_load_en), .xr_load_val(xr_load_val),
    .xr_value(xr_value), .res_valid(res_valid), .res_ea(res_ea),
    .res_sum(res_sum), .res_xr_we(res_xr_we), .res_xr_new(res_xr_new)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: drives a request and pushes the expected result.
  task automatic send(input logic [1:0] m, input logic [9:0] d,
                      input bit ld, input logic [31:0] ldv, input string tag);
    exp_t e;
    logic [31:0] nx;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_disp = d;
    xr_load_en = ld; xr_load_val = ldv;
    nx = mxr;
    case (m)
      2'd0: e.sum = {22'd0, d};
      2'd1: e.sum = {22'd0, d} + mxr;
      2'd2: begin e.sum = {22'd0, d} + mxr; nx = mxr + 32'd1; end
      default: begin nx = mxr - 32'd1; e.sum = {22'd0, d} + nx; end
    endcase
    e.we = m[1];
    e.xnew = nx;
    e.tag = tag;
    mxr = nx;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; xr_load_en = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b0; xr_load_en = 1'b1; xr_load_val = v;
    mxr = v;
  endtask

  // Monitor: pops and compares at each falling edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7 unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(res_sum == e.sum, {e.tag, " sum"}, res_sum, e.sum);
          chk(res_ea == e.sum[9:0], {"R6 ", e.tag, " ea"}, {22'd0, res_ea}, {22'd0, e.sum[9:0]});
          chk(res_xr_we == e.we, {e.tag, " we"}, {31'd0, res_xr_we}, {31'd0, e.we});
          chk(res_xr_new == e.xnew, {"R8 ", e.tag, " xnew"}, res_xr_new, e.xnew);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(xr_value == 0, "R1 reset xr", xr_value, 0);
    chk(res_valid == 0, "R1 reset valid", {31'd0, res_valid}, 0);
    chk(res_xr_we == 0, "R1 reset we", {31'd0, res_xr_we}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 0, "R7 idle no result", {31'd0, res_valid}, 0);

    send(2'd0, 10'h155, 0, 0, "R2 direct");
    idle();
    chk(xr_value == mxr, "R2 xr unchanged", xr_value, mxr);

    load(32'd100); idle();
    chk(xr_value == 32'd100, "R9 load", xr_value, 32'd100);
    send(2'd1, 10'd23, 0, 0, "R3 indexed");
    send(2'd1, 10'h3FF, 0, 0, "R3 indexed big");
    idle();
    chk(xr_value == 32'd100, "R3 xr unchanged", xr_value, 32'd100);

    send(2'd2, 10'd7, 0, 0, "R4 postinc a");
    send(2'd2, 10'd7, 0, 0, "R4 postinc b back-to-back");
    send(2'd3, 10'd0, 0, 0, "R5 predec a");
    send(2'd3, 10'd1, 0, 0, "R5 predec b back-to-back");
    idle();
    chk(xr_value == 32'd100, "R8 xr after steps", xr_value, 32'd100);

    load(32'd5); idle();
    send(2'd1, 10'h3FF, 0, 0, "R6 ea wrap");
    idle();

    load(32'hFFFF_FFFF); idle();
    send(2'd2, 10'd9, 0, 0, "R11 inc wrap");
    idle();
    chk(xr_value == 32'd0, "R11 inc wrap xr", xr_value, 32'd0);
    send(2'd3, 10'd4, 0, 0, "R11 dec wrap");
    idle();
    chk(xr_value == 32'hFFFF_FFFF, "R11 dec wrap xr", xr_value, 32'hFFFF_FFFF);

    load(32'd50); idle();
    send(2'd1, 10'd2, 1, 32'hDEAD_BEEF, "R10 load vs indexed");
    idle();
    chk(xr_value == 32'd50, "R10 load ignored indexed", xr_value, 32'd50);
    send(2'd2, 10'd2, 1, 32'h1234_5678, "R10 load vs postinc");
    idle();
    chk(xr_value == 32'd51, "R10 load ignored postinc", xr_value, 32'd51);

    idle(); idle();
    chk(sb.size() == 0, "R7 all results seen", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule